// File: doc/BRIEF.md
# Store Write Guard with Combinational Hold

This block watches the store port of a small in-order processor core and decides, in the same cycle in which a store appears, whether that store may reach data memory. The core presents each store as a tap made of a valid strobe, the program counter of the store instruction, the byte address, an access size and the write data. The guard drives a hold signal straight from that tap. The core uses the hold to stop the memory write at the last point before it commits. A store that touches a host-configured protected address window is held indefinitely and reported. Any other store goes through with no added cycle.

The host configures the guard through a single word write stream. The same stream also carries the program image for the core. The first sixteen words of the stream are guard settings. Every later word is passed on to the core's instruction memory, with its address rebased so that word sixteen lands at byte address zero. The core reports through a stall-active input whether it has obeyed the hold. A violation is recorded only once the core has confirmed that the offending write is held.

Top module: `store_guard_top`

## Requirements
- R1: After synchronous reset, `viol_flag`, `viol_pc`, `viol_data` and `fwd_valid` are zero, the guard is disabled, and `stall_store` is low while no store is presented.
- R2: Host words with stream index 0 to 15 are settings only and never raise `fwd_valid`.
- R3: A host word with stream index k of 16 or more appears on the clock edge after its write with `fwd_valid` high, `fwd_addr` equal to 4*(k-16) and `fwd_data` equal to the written word.
- R4: Settings word 0 is the lowest protected byte address, word 1 is the highest protected byte address (inclusive), and bit 0 of word 2 enables the guard. Settings words 3 to 15 have no effect on the verdict.
- R5: `st_size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. The store covers the bytes from `st_addr` to `st_addr` + 2^size - 1, computed without wrap-around.
- R6: With the guard enabled, `stall_store` is high in the same cycle as any valid store whose byte span overlaps the protected window.
- R7: With no violation recorded, `stall_store` is low in the same cycle as a valid store that does not overlap the window, or as any store while the guard is disabled.
- R8: A valid overlapping store presented while `st_stall_active` is high sets `viol_flag` on the next clock edge and captures its PC in `viol_pc` and its data in `viol_data`.
- R9: Once `viol_flag` is set, `stall_store` stays high on every cycle and `viol_pc` and `viol_data` keep their values until reset, whatever stores follow.
- R10: An overlapping store presented while `st_stall_active` is low is held, but no violation is recorded.
- R11: While `st_valid` is low and no violation is recorded, `stall_store` is low whatever the other tap inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_valid | input | 1 | Host stream word strobe |
| host_wr_data | input | 32 | Host stream word |
| fwd_valid | output | 1 | Forwarded program word strobe (registered) |
| fwd_addr | output | 32 | Byte address of the forwarded word in instruction memory |
| fwd_data | output | 32 | Forwarded program word |
| st_valid | input | 1 | Store tap valid |
| st_pc | input | 32 | PC of the store instruction |
| st_addr | input | 32 | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 32 | Store write data |
| st_stall_active | input | 1 | Core confirms that the store hold is in effect |
| stall_store | output | 1 | Combinational hold of the memory write |
| viol_flag | output | 1 | Sticky violation indication |
| viol_pc | output | 32 | PC of the first recorded offending store |
| viol_data | output | 32 | Data of the first recorded offending store |

## Verification
On every cycle the assertions check that a recorded violation keeps the hold asserted and freezes the captured PC. They also check that a confirmed offending store is recorded on the next edge, that no violation appears without one, that an idle tap gives no hold, and that forwarded addresses stay word aligned. Only the bench's scenarios can show the window arithmetic itself. The bench sweeps every size code across addresses on both sides of the window edges, runs with the guard disabled, and covers the rebasing of forwarded words and the way the settings words are split.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } st_size_e;

  localparam int unsigned CFG_IDX_BASE  = 0;
  localparam int unsigned CFG_IDX_LIMIT = 1;
  localparam int unsigned CFG_IDX_CTRL  = 2;
endpackage

// File: rtl/sg_cfg_stream.sv
module sg_cfg_stream #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CFG_WORDS = 16,
  parameter int unsigned IDX_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] cfg_base,
  output logic [ADDR_W-1:0] cfg_limit,
  output logic              cfg_en,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data
);
  import sg_pkg::*;

  localparam logic [IDX_W-1:0] IDX_MAX  = '1;
  localparam logic [IDX_W-1:0] IDX_CFG  = IDX_W'(CFG_WORDS);
  localparam int unsigned      BYTE_SH  = $clog2(DATA_W / 8);

  logic [IDX_W-1:0] word_idx;
  logic             is_cfg;
  logic [IDX_W-1:0] prog_idx;

  assign is_cfg   = (word_idx < IDX_CFG);
  assign prog_idx = word_idx - IDX_CFG;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_idx <= '0;
    end else if (wr_valid && word_idx != IDX_MAX) begin
      word_idx <= word_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_base  <= '0;
      cfg_limit <= '0;
      cfg_en    <= 1'b0;
    end else if (wr_valid && is_cfg) begin
      if (word_idx == IDX_W'(CFG_IDX_BASE))  cfg_base  <= ADDR_W'(wr_data);
      if (word_idx == IDX_W'(CFG_IDX_LIMIT)) cfg_limit <= ADDR_W'(wr_data);
      if (word_idx == IDX_W'(CFG_IDX_CTRL))  cfg_en    <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= wr_valid && !is_cfg;
      if (wr_valid && !is_cfg) begin
        fwd_addr <= ADDR_W'(prog_idx) << BYTE_SH;
        fwd_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sg_range_check.sv
module sg_range_check #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit
);
  import sg_pkg::*;

  logic [ADDR_W:0] span_first;
  logic [ADDR_W:0] span_last;
  logic [ADDR_W:0] span_len;

  always_comb begin
    unique case (st_size_e'(size))
      SZ_BYTE: span_len = (ADDR_W+1)'(1);
      SZ_HALF: span_len = (ADDR_W+1)'(2);
      SZ_WORD: span_len = (ADDR_W+1)'(4);
      default: span_len = (ADDR_W+1)'(8);
    endcase
  end

  assign span_first = {1'b0, addr};
  assign span_last  = span_first + span_len - 1'b1;
  assign hit = en && (span_first <= {1'b0, limit}) && (span_last >= {1'b0, base});
endmodule

// File: rtl/sg_violation.sv
module sg_violation #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic              hit,
  input  logic              st_stall_active,
  input  logic [ADDR_W-1:0] st_pc,
  input  logic [DATA_W-1:0] st_data,
  output logic              stall_store,
  output logic              viol_flag,
  output logic [ADDR_W-1:0] viol_pc,
  output logic [DATA_W-1:0] viol_data
);
  logic offend;
  logic record;

  assign offend      = st_valid && hit;
  assign stall_store = viol_flag || offend;
  assign record      = offend && st_stall_active && !viol_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_flag <= 1'b0;
      viol_pc   <= '0;
      viol_data <= '0;
    end else if (record) begin
      viol_flag <= 1'b1;
      viol_pc   <= st_pc;
      viol_data <= st_data;
    end
  end
endmodule

// File: rtl/store_guard_top.sv
module store_guard_top #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CFG_WORDS = 16,
  parameter int unsigned IDX_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_valid,
  input  logic [DATA_W-1:0] host_wr_data,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_pc,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_stall_active,
  output logic              stall_store,
  output logic              viol_flag,
  output logic [ADDR_W-1:0] viol_pc,
  output logic [DATA_W-1:0] viol_data
);
  logic [ADDR_W-1:0] cfg_base;
  logic [ADDR_W-1:0] cfg_limit;
  logic              cfg_en;
  logic              hit;

  sg_cfg_stream #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_WORDS(CFG_WORDS), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .wr_valid(host_wr_valid), .wr_data(host_wr_data),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_en(cfg_en),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data)
  );

  sg_range_check #(.ADDR_W(ADDR_W)) u_rng (
    .en(cfg_en), .base(cfg_base), .limit(cfg_limit),
    .addr(st_addr), .size(st_size), .hit(hit)
  );

  sg_violation #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_viol (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .hit(hit), .st_stall_active(st_stall_active),
    .st_pc(st_pc), .st_data(st_data),
    .stall_store(stall_store), .viol_flag(viol_flag),
    .viol_pc(viol_pc), .viol_data(viol_data)
  );
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              st_valid,
  input logic              st_stall_active,
  input logic              stall_store,
  input logic              viol_flag,
  input logic [ADDR_W-1:0] viol_pc,
  input logic              fwd_valid,
  input logic [ADDR_W-1:0] fwd_addr
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!viol_flag && !fwd_valid));

  p_fwd_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> (fwd_addr[1:0] == 2'b00));

  p_record_next_r8: assert property (@(posedge clk) disable iff (rst)
    (st_valid && stall_store && st_stall_active) |=> viol_flag);

  p_hold_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    viol_flag |-> stall_store);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    viol_flag |=> viol_flag);

  p_pc_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (viol_flag && $past(viol_flag)) |-> $stable(viol_pc));

  p_no_record_r10: assert property (@(posedge clk) disable iff (rst)
    (!viol_flag && !(st_valid && stall_store && st_stall_active)) |=> !viol_flag);

  p_idle_free_r11: assert property (@(posedge clk) disable iff (rst)
    (!st_valid && !viol_flag) |-> !stall_store);
endmodule

bind store_guard_top sg_checker #(.ADDR_W(ADDR_W)) u_sg_checker (
  .clk(clk), .rst(rst),
  .st_valid(st_valid), .st_stall_active(st_stall_active),
  .stall_store(stall_store), .viol_flag(viol_flag), .viol_pc(viol_pc),
  .fwd_valid(fwd_valid), .fwd_addr(fwd_addr)
);

// File: tb/test_store_guard_top.sv
`timescale 1ns/1ps
module test_store_guard_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_wr_valid;
  logic [31:0] host_wr_data;
  logic        fwd_valid;
  logic [31:0] fwd_addr;
  logic [31:0] fwd_data;
  logic        st_valid;
  logic [31:0] st_pc;
  logic [31:0] st_addr;
  logic [1:0]  st_size;
  logic [31:0] st_data;
  logic        st_stall_active;
  logic        stall_store;
  logic        viol_flag;
  logic [31:0] viol_pc;
  logic [31:0] viol_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  store_guard_top i_store_guard_top (
    .clk(clk), .rst(rst),
    .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
    .st_valid(st_valid), .st_pc(st_pc), .st_addr(st_addr), .st_size(st_size),
    .st_data(st_data), .st_stall_active(st_stall_active),
    .stall_store(stall_store), .viol_flag(viol_flag),
    .viol_pc(viol_pc), .viol_data(viol_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input bit en, input longint base, input longint lim,
                                   input longint a, input int sz);
    longint last = a + (longint'(1) << sz) - 1;
    return en && (a <= lim) && (last >= base);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; host_wr_valid = 1'b0; host_wr_data = '0;
    st_valid = 1'b0; st_pc = '0; st_addr = '0; st_size = '0; st_data = '0;
    st_stall_active = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic host_write(input logic [31:0] w);
    @(negedge clk);
    host_wr_valid = 1'b1; host_wr_data = w;
    @(posedge clk); #1;
    host_wr_valid = 1'b0;
  endtask

  task automatic load_cfg(input logic [31:0] base, input logic [31:0] lim, input logic [31:0] ctrl);
    for (int k = 0; k < 16; k++) begin
      logic [31:0] w;
      if (k == 0) w = base;
      else if (k == 1) w = lim;
      else if (k == 2) w = ctrl;
      else w = 32'hFFFF_0000 | k;
      host_write(w);
      check("R2 cfg word not forwarded", {31'b0, fwd_valid}, 32'd0);
    end
  endtask

  task automatic sweep(input bit en, input longint base, input longint lim);
    for (int sz = 0; sz < 4; sz++) begin
      for (longint a = base - 12; a <= lim + 4; a++) begin
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'(a); st_size = 2'(sz);
        st_pc = 32'h2000 + 32'(a); st_data = 32'(a) ^ 32'h5A5A_5A5A;
        st_stall_active = 1'b0;
        #1;
        if (model_hit(en, base, lim, a, sz))
          check("R6 R5 overlapping store held", {31'b0, stall_store}, 32'd1);
        else
          check("R7 R5 clear store not held", {31'b0, stall_store}, 32'd0);
      end
    end
    @(negedge clk);
    st_valid = 1'b0;
    #1;
    check("R10 no violation without stall_active", {31'b0, viol_flag}, 32'd0);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    check("R1 viol_flag after reset", {31'b0, viol_flag}, 32'd0);
    check("R1 viol_pc after reset", viol_pc, 32'd0);
    check("R1 viol_data after reset", viol_data, 32'd0);
    check("R1 fwd_valid after reset", {31'b0, fwd_valid}, 32'd0);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h0; st_size = 2'd2; #1;
    check("R1 guard disabled after reset", {31'b0, stall_store}, 32'd0);
    st_valid = 1'b0;

    // Guard disabled via ctrl bit 0 = 0 (other bits set): nothing held (R4, R7)
    load_cfg(32'h100, 32'h10F, 32'hFFFF_FFFE);
    sweep(1'b0, 64'h100, 64'h10F);

    // Enabled window 0x100..0x10F; junk in words 3..15 ignored (R4)
    do_reset();
    load_cfg(32'h100, 32'h10F, 32'h1);
    sweep(1'b1, 64'h100, 64'h10F);

    // R11: idle tap with overlapping address fields
    @(negedge clk);
    st_valid = 1'b0; st_addr = 32'h104; st_size = 2'd2; st_stall_active = 1'b1; #1;
    check("R11 idle tap no hold", {31'b0, stall_store}, 32'd0);
    @(posedge clk); #1;
    check("R11 idle tap no record", {31'b0, viol_flag}, 32'd0);

    // R3: program words after the settings block
    for (int k = 16; k < 24; k++) begin
      host_write(32'hC0DE_0000 + k);
      check("R3 fwd_valid", {31'b0, fwd_valid}, 32'd1);
      check("R3 fwd_addr", fwd_addr, 32'(4 * (k - 16)));
      check("R3 fwd_data", fwd_data, 32'hC0DE_0000 + k);
    end
    @(posedge clk); #1;
    check("R3 fwd_valid drops when idle", {31'b0, fwd_valid}, 32'd0);

    // R10 explicit: offending store, no stall_active
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h10E; st_size = 2'd1; st_pc = 32'hAAAA_0001;
    st_data = 32'h1111_1111; st_stall_active = 1'b0; #1;
    check("R10 held", {31'b0, stall_store}, 32'd1);
    @(posedge clk); #1;
    check("R10 not recorded", {31'b0, viol_flag}, 32'd0);

    // R8: confirmed offending store
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h0FE; st_size = 2'd2; st_pc = 32'hBEEF_0040;
    st_data = 32'hDEAD_BEEF; st_stall_active = 1'b1; #1;
    check("R8 held", {31'b0, stall_store}, 32'd1);
    @(posedge clk); #1;
    check("R8 viol_flag", {31'b0, viol_flag}, 32'd1);
    check("R8 viol_pc", viol_pc, 32'hBEEF_0040);
    check("R8 viol_data", viol_data, 32'hDEAD_BEEF);

    // R9: second offender and clean / idle stores after violation
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h108; st_size = 2'd0; st_pc = 32'h1234_5678;
    st_data = 32'h0; st_stall_active = 1'b1;
    @(posedge clk); #1;
    check("R9 pc kept", viol_pc, 32'hBEEF_0040);
    check("R9 data kept", viol_data, 32'hDEAD_BEEF);
    @(negedge clk);
    st_addr = 32'h400; st_stall_active = 1'b0; #1;
    check("R9 clean store still held", {31'b0, stall_store}, 32'd1);
    @(negedge clk);
    st_valid = 1'b0; #1;
    check("R9 idle still held", {31'b0, stall_store}, 32'd1);

    do_reset();
    #1;
    check("R1 reset clears violation", {31'b0, viol_flag}, 32'd0);
    check("R1 reset clears hold", {31'b0, stall_store}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule